// File: doc/BRIEF.md
# Interlocked Pipeline Hazard Controller

This block is the hazard and flow-control logic for a six-stage in-order pipeline: PC generation, fetch, decode, execute, memory and writeback. The next PC comes from a stage of its own ahead of fetch. The pipeline has no operand bypass paths, so every read-after-write dependence is handled by holding the reader in decode. It waits there until no valid older instruction that writes its source register remains in execute, memory or writeback.

Each cycle the controller takes the per-stage valid bits, the destination register and write enable of the three downstream stages, the source registers of the instruction in decode, the busy flags of the instruction and data bus ports, and a branch mispredict indication with its corrected target. From these it produces one stall and one flush bit per stage, plus a redirect toward PC generation.

The stall and flush bits act on the pipeline register of each stage. A stalled stage keeps its content. A flushed stage loads a bubble at the next edge. A stage that is neither loads from the stage before it. A stall caused at stage N holds stages 0 to N and puts a bubble into stage N+1. When nothing blocks, every stage advances on every clock, so one instruction is issued and one retired per cycle.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, `redirect_vld_o` is low in the following cycle.
- R2: Bit i of `stall_o` and `flush_o` refers to stage i, with 0 PC generation, 1 fetch, 2 decode, 3 execute, 4 memory and 5 writeback. `stage_vld_i` carries bits 1 to 5 in the same numbering. With no hazard, no busy bus and no mispredict, both `stall_o` and `flush_o` are all zero.
- R3: A RAW hazard stalls decode. The hazard exists when decode is valid, an enabled source matches the destination of a valid, writing instruction in execute, memory or writeback. The result is `stall_o` bits 0 to 2 set, bits 3 to 5 clear, and `flush_o` equal to 6'b001000.
- R4: A source register number of zero never raises a hazard, even when a valid producer writes register zero.
- R5: No hazard is raised when the matching producer has its write enable low, when the producer stage is not valid, when the source enable is low, or when decode is not valid.
- R6: A busy instruction bus with fetch valid gives `stall_o` = 6'b000011 and `flush_o` = 6'b000100.
- R7: A busy data bus with memory valid sets `stall_o` bits 1 to 4 and clears bit 5. It gives `flush_o` = 6'b100000, whatever the fetch and decode sources are.
- R8: A mispredict is taken when it arrives with execute valid and execute not stalled. Then `flush_o` bits 0 to 3 are set and `stall_o` bits 0 to 3 are clear, overriding any fetch or decode stall.
- R9: In the cycle after a taken mispredict, `redirect_vld_o` is high for exactly that cycle, and `redirect_pc_o` holds the target that came with the mispredict. In that cycle `stall_o[0]` is low, so PC generation loads the target.
- R10: A mispredict arriving with execute not valid, or with a busy data bus and memory valid, is ignored. No flush bits are raised for it and `redirect_vld_o` stays low in the next cycle.
- R11: When several stall sources below memory are active, the highest one sets the stall depth. Outside a taken mispredict, at most one `flush_o` bit is set.
- R12: A busy flag from a bus port whose stage is not valid causes no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stage_vld_i | input | 5 | Valid bits of stages 1 (fetch) to 5 (writeback) |
| ex_rd_i | input | RAW | Destination register of the execute instruction |
| ex_we_i | input | 1 | Execute instruction writes a register |
| mem_rd_i | input | RAW | Destination register of the memory instruction |
| mem_we_i | input | 1 | Memory instruction writes a register |
| wb_rd_i | input | RAW | Destination register of the writeback instruction |
| wb_we_i | input | 1 | Writeback instruction writes a register |
| dec_rs1_i | input | RAW | First source register in decode |
| dec_rs1_en_i | input | 1 | First source is read |
| dec_rs2_i | input | RAW | Second source register in decode |
| dec_rs2_en_i | input | 1 | Second source is read |
| ibus_busy_i | input | 1 | Instruction bus transaction not yet answered |
| dbus_busy_i | input | 1 | Data bus transaction not yet answered |
| mispredict_i | input | 1 | Branch in execute was mispredicted |
| mispredict_pc_i | input | XLEN | Corrected fetch address |
| stall_o | output | 6 | Per-stage hold |
| flush_o | output | 6 | Per-stage bubble load |
| redirect_vld_o | output | 1 | PC generation loads redirect_pc_o |
| redirect_pc_o | output | XLEN | Redirect target |

## Verification
The hazard comparator is driven with a source matching, in turn, the execute, memory and writeback destinations, using both source slots. This shows the three producer comparisons are wired separately. Near-miss patterns then take away one condition at a time: register zero, write enable low, producer invalid, source enable low and decode empty. These separate a real dependence from each false trigger. The bus busy flags are applied alone, stacked on top of a decode hazard, and from empty stages, which exposes how deep the freeze goes and where the single bubble lands. Mispredicts are sent both with pending stalls and in their ignored conditions. The cycle after each is checked to tell a taken redirect from a dropped one.

// File: rtl/hz_pkg.sv
// Shared constants for the pipeline hazard controller.
// Assumes a fixed six-stage in-order pipeline; stage numbers are bit indices.
package hz_pkg;
    localparam int unsigned N_STAGE = 6;
    localparam int unsigned ST_PCG  = 0;
    localparam int unsigned ST_FET  = 1;
    localparam int unsigned ST_DEC  = 2;
    localparam int unsigned ST_EXE  = 3;
    localparam int unsigned ST_MEM  = 4;
    localparam int unsigned ST_WB   = 5;
    // Producers compared against decode sources: execute, memory, writeback
    localparam int unsigned N_PROD  = ST_WB - ST_EXE + 1;

    typedef logic [N_STAGE-1:0] stage_vec_t;
endpackage

// File: rtl/hz_raw_detect.sv
// Read-after-write detector for the instruction in decode.
// Compares both enabled, non-zero sources against every live producer.
// Assumes the register file is written at the end of writeback, so the
// writeback stage still counts as a producer.
module hz_raw_detect #(
    parameter int unsigned RAW   = 5,
    parameter int unsigned NPROD = 3
) (
    input  logic                       dec_vld,
    input  logic [RAW-1:0]             rs1,
    input  logic                       rs1_en,
    input  logic [RAW-1:0]             rs2,
    input  logic                       rs2_en,
    input  logic [NPROD-1:0][RAW-1:0]  prod_rd,
    input  logic [NPROD-1:0]           prod_live,
    output logic                       hazard
);
    logic [NPROD-1:0] hit1;
    logic [NPROD-1:0] hit2;
    logic             need1;
    logic             need2;

    // One comparator pair per producer stage
    for (genvar p = 0; p < NPROD; p++) begin : g_prod
        assign hit1[p] = prod_live[p] && (prod_rd[p] == rs1);
        assign hit2[p] = prod_live[p] && (prod_rd[p] == rs2);
    end

    // Register zero is hard-wired and never waits for anyone
    assign need1 = rs1_en && (rs1 != '0);
    assign need2 = rs2_en && (rs2 != '0);

    // Combine per-source results for the decode slot
    assign hazard = dec_vld && ((need1 && (|hit1)) || (need2 && (|hit2)));
endmodule

// File: rtl/hz_stall_chain.sv
// Turns per-stage stall sources into cumulative holds and a bubble mask.
// A source at stage N holds stages 0..N and loads a bubble into N+1.
// Assumes nothing about which stages carry sources.
module hz_stall_chain #(
    parameter int unsigned N = 6
) (
    input  logic [N-1:0] src,
    output logic [N-1:0] hold,
    output logic [N-1:0] bubble
);
    for (genvar i = 0; i < N; i++) begin : g_stage
        // Stage i holds when it or any later stage is blocked
        assign hold[i] = |src[N-1:i];
        if (i == 0) begin : g_first
            // Nothing feeds stage 0 from behind, so it never takes a bubble
            assign bubble[i] = 1'b0;
        end else begin : g_rest
            // First unblocked stage past a held one receives the bubble
            assign bubble[i] = hold[i-1] && !hold[i];
        end
    end
endmodule

// File: rtl/hz_redirect.sv
// Branch-mispredict qualifier and registered redirect toward PC generation.
// A mispredict is taken only when the branch in execute is valid and
// moving on; the redirect is presented in the following cycle.
module hz_redirect #(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mispredict,
    input  logic            br_vld,
    input  logic            br_held,
    input  logic [XLEN-1:0] target,
    output logic            take,
    output logic            rvld,
    output logic [XLEN-1:0] rpc
);
    // Act only on a live branch that is leaving execute this cycle
    assign take = mispredict && br_vld && !br_held;

    // Capture the corrected target for one cycle of redirect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvld <= 1'b0;
            rpc  <= '0;
        end else begin
            rvld <= take;
            if (take) begin
                rpc <= target;
            end
        end
    end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
// Interlocked hazard controller for a six-stage in-order pipeline.
// Produces per-stage stall and flush plus a PC redirect. Assumes no bypass
// network, one outstanding transaction per bus, and branches resolved in
// execute. Flush overrides stall on the stages it kills.
module pipe_hazard_ctrl
    import hz_pkg::*;
#(
    parameter int unsigned XLEN = 32,
    parameter int unsigned RAW  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_STAGE-1:1]   stage_vld_i,
    input  logic [RAW-1:0]       ex_rd_i,
    input  logic                 ex_we_i,
    input  logic [RAW-1:0]       mem_rd_i,
    input  logic                 mem_we_i,
    input  logic [RAW-1:0]       wb_rd_i,
    input  logic                 wb_we_i,
    input  logic [RAW-1:0]       dec_rs1_i,
    input  logic                 dec_rs1_en_i,
    input  logic [RAW-1:0]       dec_rs2_i,
    input  logic                 dec_rs2_en_i,
    input  logic                 ibus_busy_i,
    input  logic                 dbus_busy_i,
    input  logic                 mispredict_i,
    input  logic [XLEN-1:0]      mispredict_pc_i,
    output logic [N_STAGE-1:0]   stall_o,
    output logic [N_STAGE-1:0]   flush_o,
    output logic                 redirect_vld_o,
    output logic [XLEN-1:0]      redirect_pc_o
);
    // Stages at or before the branch stage hold wrong-path work
    localparam stage_vec_t KILL_MASK = stage_vec_t'((1 << (ST_EXE + 1)) - 1);

    logic [N_PROD-1:0][RAW-1:0] prod_rd;
    logic [N_PROD-1:0]          prod_live;
    logic                       raw_hazard;
    stage_vec_t                 stall_src;
    stage_vec_t                 chain_hold;
    stage_vec_t                 chain_bubble;
    logic                       br_take;
    logic                       rdr_vld;
    logic [XLEN-1:0]            rdr_pc;

    // Gather producer destinations in stage order
    assign prod_rd[0]   = ex_rd_i;
    assign prod_rd[1]   = mem_rd_i;
    assign prod_rd[2]   = wb_rd_i;
    assign prod_live[0] = stage_vld_i[ST_EXE] && ex_we_i;
    assign prod_live[1] = stage_vld_i[ST_MEM] && mem_we_i;
    assign prod_live[2] = stage_vld_i[ST_WB]  && wb_we_i;

    hz_raw_detect #(
        .RAW   (RAW),
        .NPROD (N_PROD)
    ) u_raw (
        .dec_vld   (stage_vld_i[ST_DEC]),
        .rs1       (dec_rs1_i),
        .rs1_en    (dec_rs1_en_i),
        .rs2       (dec_rs2_i),
        .rs2_en    (dec_rs2_en_i),
        .prod_rd   (prod_rd),
        .prod_live (prod_live),
        .hazard    (raw_hazard)
    );

    // Place each stall source at the stage that must wait
    always_comb begin
        stall_src         = '0;
        stall_src[ST_FET] = ibus_busy_i && stage_vld_i[ST_FET];
        stall_src[ST_DEC] = raw_hazard;
        stall_src[ST_MEM] = dbus_busy_i && stage_vld_i[ST_MEM];
    end

    hz_stall_chain #(
        .N (N_STAGE)
    ) u_chain (
        .src    (stall_src),
        .hold   (chain_hold),
        .bubble (chain_bubble)
    );

    hz_redirect #(
        .XLEN (XLEN)
    ) u_rdr (
        .clk        (clk),
        .rst_n      (rst_n),
        .mispredict (mispredict_i),
        .br_vld     (stage_vld_i[ST_EXE]),
        .br_held    (chain_hold[ST_EXE]),
        .target     (mispredict_pc_i),
        .take       (br_take),
        .rvld       (rdr_vld),
        .rpc        (rdr_pc)
    );

    // Merge flush over stall, and free PC generation for a redirect load
    always_comb begin
        stall_o = chain_hold;
        flush_o = chain_bubble;
        if (br_take) begin
            stall_o = stall_o & ~KILL_MASK;
            flush_o = flush_o | KILL_MASK;
        end
        if (rdr_vld) begin
            stall_o[ST_PCG] = 1'b0;
        end
    end

    assign redirect_vld_o = rdr_vld;
    assign redirect_pc_o  = rdr_pc;
endmodule

// File: rtl/hz_ctrl_checks.sv
// Property checker for pipe_hazard_ctrl, attached through bind.
// Observes ports only; assumes the synchronous active-low reset.
module hz_ctrl_checks
    import hz_pkg::*;
#(
    parameter int unsigned XLEN = 32,
    parameter int unsigned RAW  = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dec_vld,
    input logic               exe_vld,
    input logic               mem_vld,
    input logic [RAW-1:0]     ex_rd_i,
    input logic               ex_we_i,
    input logic [RAW-1:0]     dec_rs1_i,
    input logic               dec_rs1_en_i,
    input logic [RAW-1:0]     dec_rs2_i,
    input logic               ibus_busy_i,
    input logic               dbus_busy_i,
    input logic               mispredict_i,
    input logic [XLEN-1:0]    mispredict_pc_i,
    input logic [N_STAGE-1:0] stall_o,
    input logic [N_STAGE-1:0] flush_o,
    input logic               redirect_vld_o,
    input logic [XLEN-1:0]    redirect_pc_o
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> !redirect_vld_o);

    assert_quiet_flow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ibus_busy_i && !dbus_busy_i && !mispredict_i && !dec_vld)
        |-> (stall_o == '0 && flush_o == '0));

    assert_raw_ex_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && dec_rs1_en_i && dec_rs1_i != '0 && exe_vld && ex_we_i
         && ex_rd_i == dec_rs1_i && !mispredict_i)
        |-> stall_o[ST_DEC]);

    assert_zero_reg_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ibus_busy_i && !dbus_busy_i && !mispredict_i
         && dec_rs1_i == '0 && dec_rs2_i == '0)
        |-> (stall_o == '0));

    assert_dbus_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dbus_busy_i && mem_vld)
        |-> ((&stall_o[ST_MEM:ST_FET]) && !stall_o[ST_WB]
             && flush_o == stage_vec_t'(1 << ST_WB)));

    assert_flush_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_o & stall_o) == '0);

    assert_redirect_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mispredict_i && exe_vld && !(dbus_busy_i && mem_vld))
        |=> (redirect_vld_o && redirect_pc_o == $past(mispredict_pc_i)));

    assert_mispredict_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mispredict_i && (!exe_vld || (dbus_busy_i && mem_vld)))
        |=> !redirect_vld_o);

    assert_single_bubble_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_o[ST_PCG] |-> $onehot0(flush_o));
endmodule

bind pipe_hazard_ctrl hz_ctrl_checks #(
    .XLEN (XLEN),
    .RAW  (RAW)
) u_checks (
    .clk             (clk),
    .rst_n           (rst_n),
    .dec_vld         (stage_vld_i[2]),
    .exe_vld         (stage_vld_i[3]),
    .mem_vld         (stage_vld_i[4]),
    .ex_rd_i         (ex_rd_i),
    .ex_we_i         (ex_we_i),
    .dec_rs1_i       (dec_rs1_i),
    .dec_rs1_en_i    (dec_rs1_en_i),
    .dec_rs2_i       (dec_rs2_i),
    .ibus_busy_i     (ibus_busy_i),
    .dbus_busy_i     (dbus_busy_i),
    .mispredict_i    (mispredict_i),
    .mispredict_pc_i (mispredict_pc_i),
    .stall_o         (stall_o),
    .flush_o         (flush_o),
    .redirect_vld_o  (redirect_vld_o),
    .redirect_pc_o   (redirect_pc_o)
);

// File: tb/tb_pipe_hazard_ctrl.sv
// Scoreboard bench: step() drives one cycle of inputs and queues the
// expected outputs; a monitor pops and compares at the falling edge.
`timescale 1ns/1ps
module tb_pipe_hazard_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:1]  vld = '0;
    logic [4:0]  ex_rd = '0, mem_rd = '0, wb_rd = '0, rs1 = '0, rs2 = '0;
    logic        ex_we = 1'b0, mem_we = 1'b0, wb_we = 1'b0;
    logic        rs1_en = 1'b0, rs2_en = 1'b0, ibusy = 1'b0, dbusy = 1'b0, mis = 1'b0;
    logic [31:0] tgt = '0;
    logic [5:0]  stall, flush;
    logic        rvld;
    logic [31:0] rpc;

    // staged values, copied onto the DUT inputs just after a rising edge
    logic [5:1]  s_vld;
    logic [4:0]  s_ex_rd, s_mem_rd, s_wb_rd, s_rs1, s_rs2;
    logic        s_ex_we, s_mem_we, s_wb_we, s_rs1_en, s_rs2_en, s_ibusy, s_dbusy, s_mis;
    logic [31:0] s_tgt;

    logic [5:0]  st_q[$];
    logic [5:0]  fl_q[$];
    logic        rv_q[$];
    logic [31:0] pc_q[$];
    string       tag_q[$];

    logic        pend_v = 1'b0;
    logic [31:0] pend_pc = '0;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    pipe_hazard_ctrl #(.XLEN(32), .RAW(5)) dut (
        .clk(clk), .rst_n(rst_n), .stage_vld_i(vld),
        .ex_rd_i(ex_rd), .ex_we_i(ex_we), .mem_rd_i(mem_rd), .mem_we_i(mem_we),
        .wb_rd_i(wb_rd), .wb_we_i(wb_we),
        .dec_rs1_i(rs1), .dec_rs1_en_i(rs1_en), .dec_rs2_i(rs2), .dec_rs2_en_i(rs2_en),
        .ibus_busy_i(ibusy), .dbus_busy_i(dbusy),
        .mispredict_i(mis), .mispredict_pc_i(tgt),
        .stall_o(stall), .flush_o(flush),
        .redirect_vld_o(rvld), .redirect_pc_o(rpc)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        s_vld = 5'b11111;
        s_ex_rd = 5'd5; s_mem_rd = 5'd6; s_wb_rd = 5'd7;
        s_ex_we = 1'b1; s_mem_we = 1'b1; s_wb_we = 1'b1;
        s_rs1 = 5'd1; s_rs2 = 5'd2; s_rs1_en = 1'b1; s_rs2_en = 1'b1;
        s_ibusy = 1'b0; s_dbusy = 1'b0; s_mis = 1'b0; s_tgt = '0;
    endtask

    function automatic logic src_hit(input logic [4:0] rs, input logic en);
        return en && rs != 5'd0 &&
               ((vld[3] && ex_we && ex_rd == rs) ||
                (vld[4] && mem_we && mem_rd == rs) ||
                (vld[5] && wb_we && wb_rd == rs));
    endfunction

    // Drive one cycle and queue its expected outputs (from R2..R12)
    task automatic step(input string tag);
        logic [5:0] src, st, fl;
        logic       tk;
        @(posedge clk);
        #1;
        vld = s_vld; ex_rd = s_ex_rd; mem_rd = s_mem_rd; wb_rd = s_wb_rd;
        ex_we = s_ex_we; mem_we = s_mem_we; wb_we = s_wb_we;
        rs1 = s_rs1; rs2 = s_rs2; rs1_en = s_rs1_en; rs2_en = s_rs2_en;
        ibusy = s_ibusy; dbusy = s_dbusy; mis = s_mis; tgt = s_tgt;
        src = '0;
        src[1] = ibusy && vld[1];
        src[2] = vld[2] && (src_hit(rs1, rs1_en) || src_hit(rs2, rs2_en));
        src[4] = dbusy && vld[4];
        for (int i = 0; i < 6; i++) begin
            st[i] = |(src >> i);
        end
        fl = '0;
        for (int i = 1; i < 6; i++) begin
            fl[i] = st[i-1] && !st[i];
        end
        tk = mis && vld[3] && !st[3];
        if (tk) begin
            st[3:0] = 4'h0;
            fl[3:0] = 4'hf;
        end
        if (pend_v) st[0] = 1'b0;
        st_q.push_back(st); fl_q.push_back(fl);
        rv_q.push_back(pend_v); pc_q.push_back(pend_pc);
        tag_q.push_back(tag);
        pend_v = tk;
        if (tk) pend_pc = tgt;
    endtask

    // Monitor: compare each queued item in the middle of its cycle
    always @(negedge clk) begin
        if (tag_q.size() != 0) begin
            logic [5:0]  est, efl;
            logic        erv;
            logic [31:0] epc;
            string       t;
            est = st_q.pop_front(); efl = fl_q.pop_front();
            erv = rv_q.pop_front(); epc = pc_q.pop_front();
            t = tag_q.pop_front();
            check(stall === est, t, "stall", 32'(stall), 32'(est));
            check(flush === efl, t, "flush", 32'(flush), 32'(efl));
            check(rvld === erv, t, "redirect_vld", 32'(rvld), 32'(erv));
            if (erv) check(rpc === epc, t, "redirect_pc", rpc, epc);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle();
        // R1: reset holds the redirect low even with a takeable mispredict
        vld = 5'b11111; mis = 1'b1; tgt = 32'hdead_beef;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rvld === 1'b0, "R1", "redirect_vld in reset", 32'(rvld), 32'd0);
        @(posedge clk);
        #1;
        mis = 1'b0;
        rst_n = 1'b1;

        idle(); step("R2 idle");
        step("R2 idle stream");
        step("R2 idle stream");
        idle(); s_rs1 = 5'd5; step("R3 rs1 vs execute");
        idle(); s_rs2 = 5'd6; step("R3 rs2 vs memory");
        idle(); s_rs1 = 5'd7; step("R3 rs1 vs writeback");
        idle(); s_rs1 = 5'd0; s_rs2 = 5'd0; s_ex_rd = 5'd0; s_mem_rd = 5'd0;
        step("R4 register zero");
        idle(); s_rs1 = 5'd5; s_ex_we = 1'b0; step("R5 write enable low");
        idle(); s_rs1 = 5'd5; s_vld[3] = 1'b0; step("R5 producer invalid");
        idle(); s_rs1 = 5'd5; s_rs1_en = 1'b0; step("R5 source unused");
        idle(); s_rs2 = 5'd7; s_vld[2] = 1'b0; step("R5 decode empty");
        idle(); s_ibusy = 1'b1; step("R6 fetch bus busy");
        idle(); s_ibusy = 1'b1; s_vld[1] = 1'b0; step("R12 fetch empty");
        idle(); s_dbusy = 1'b1; s_ibusy = 1'b1; s_rs1 = 5'd5; step("R7 data bus dominates");
        idle(); s_dbusy = 1'b1; s_vld[4] = 1'b0; step("R12 memory empty");
        idle(); s_ibusy = 1'b1; s_rs1 = 5'd6; step("R11 highest source wins");
        idle(); s_mis = 1'b1; s_tgt = 32'h8000_1234; s_rs1 = 5'd5; s_ibusy = 1'b1;
        step("R8 mispredict over stalls");
        idle(); s_ibusy = 1'b1; step("R9 redirect cycle");
        idle(); step("R9 redirect ends");
        idle(); s_mis = 1'b1; s_tgt = 32'h0000_0040; s_vld[3] = 1'b0;
        step("R10 execute empty");
        idle(); step("R10 no redirect after empty");
        idle(); s_mis = 1'b1; s_tgt = 32'h0000_0080; s_dbusy = 1'b1;
        step("R10 execute held");
        idle(); step("R10 no redirect after held");
        idle(); s_mis = 1'b1; s_tgt = 32'h0000_0c00; step("R8 plain mispredict");
        idle(); step("R9 second redirect");
        idle(); step("R2 resume");

        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule